// File: doc/BRIEF.md
# Transport Packet Output Formatter

The formatter takes a stream of decoded transport-stream bytes and drives them onto an output port, either a whole byte at a time or one bit at a time on a single pin. Each output word takes two clock cycles: `dclk_o` is low in the first and high in the second. `dout_o` is set at the start of the low cycle and holds through the high cycle, so a receiver that samples on the rising edge of `dclk_o` sees stable data. `dvalid_o` qualifies every word. `fsync_o` marks the first word of each packet, and `dstb_o` marks the start of each byte.

The packet length is either 188 or 144 bytes. Four settings are sampled only when the first byte of a packet is accepted: packet length, serial or parallel output, gapped or evenly paced output, and the pace gap. A change to these inputs partway through a packet therefore waits for the next packet. When the formatter sits at a packet boundary, it accepts and drops any byte that does not carry the start-of-packet marker. This lets it lock onto packet starts after reset. `in_ready_o` stalls the source while a byte is still being shifted out.

Top module: `ts_out_fmt`

## Requirements
- R1: A packet is 188 bytes when `fmt_dss_i`=0 and 144 bytes when `fmt_dss_i`=1. The value is taken when the packet's first byte is accepted.
- R2: In parallel mode (`serial_i`=0), each byte is one output word on `dout_o[7:0]`.
- R3: In serial mode (`serial_i`=1), each byte is eight words on `dout_o[0]`, sent MSB first, with `dout_o[7:1]` held at 0.
- R4: `fsync_o` is high on the first word of each packet and on no other word. `dstb_o` is high only in the high cycle of the first word of each byte (every word in parallel mode, bit 7 in serial mode).
- R5: Every word lasts two cycles, the first with `dclk_o` low and the second with `dclk_o` high. `dvalid_o` is high in both cycles and `dout_o` is identical in both.
- R6: With input always available, consecutive words start 2 cycles apart when `regulated_i`=0, and 2+`pace_i` cycles apart when `regulated_i`=1. This spacing also holds across byte and packet boundaries.
- R7: At a packet boundary, a byte offered without `in_sop_i` is accepted and dropped. It produces no output.
- R8: A change to `fmt_dss_i`, `serial_i`, `regulated_i` or `pace_i` during a packet has no effect until the next packet's first byte.
- R9: `in_ready_o` is low from the cycle after a byte is accepted until the high cycle of that byte's last word. In serial gapped mode this is 15 cycles.
- R10: While reset is held and right after it, `dvalid_o`, `dclk_o`, `dstb_o`, `fsync_o` and `dout_o` are 0 and `in_ready_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_data_i | input | 8 | Input byte |
| in_sop_i | input | 1 | Input byte is the first of a packet |
| in_valid_i | input | 1 | Input byte offered |
| in_ready_o | output | 1 | Input byte taken at this edge when valid |
| fmt_dss_i | input | 1 | 1 selects 144-byte packets, 0 selects 188-byte packets |
| serial_i | input | 1 | 1 selects bit-serial output on `dout_o[0]` |
| regulated_i | input | 1 | 1 inserts `pace_i` idle cycles after each word |
| pace_i | input | 8 | Idle cycles between words in regulated mode |
| dout_o | output | 8 | Output word |
| dclk_o | output | 1 | Output data clock, high in the second cycle of a word |
| dstb_o | output | 1 | Byte-start strobe |
| fsync_o | output | 1 | Packet-start marker |
| dvalid_o | output | 1 | Output word valid |

## Verification
A byte accepted at a clock edge starts its low cycle right after that edge, and its high cycle follows one edge later. The input handshake becomes ready again in that high cycle of the last word, or `pace_i` cycles later when pacing is on. The bench samples all outputs at falling edges and records one word per high cycle, with the cycle number attached. This lets it compare word order, marker placement and start-to-start spacing against values computed from the requirements, without assuming any absolute latency. The stall length after an accepted byte is counted in falling edges, from the first edge after acceptance until `in_ready_o` rises.

// File: rtl/ts_out_pkg.sv
package ts_out_pkg;
  localparam int DVB_LEN = 188;
  localparam int DSS_LEN = 144;
  localparam int PACE_W  = 8;
  localparam int CNT_W   = $clog2(DVB_LEN);

  typedef struct packed {
    logic              dss;
    logic              ser;
    logic              reg_mode;
    logic [PACE_W-1:0] pace;
  } cfg_t;
endpackage

// File: rtl/ts_out_pkt_ctl.sv
module ts_out_pkt_ctl
  import ts_out_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cfg_t cfg_live_i,
  input  logic take_i,
  input  logic sop_i,
  output logic load_o,
  output logic first_o,
  output cfg_t cfg_o
);
  localparam logic [CNT_W-1:0] DVB_M1 = CNT_W'(DVB_LEN - 1);
  localparam logic [CNT_W-1:0] DSS_M1 = CNT_W'(DSS_LEN - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_m1;
  logic             at_bound;
  cfg_t             cfg_q;

  assign at_bound = (cnt_q == '0);
  // bytes without a start marker are dropped while hunting for a packet start
  assign load_o   = take_i && (!at_bound || sop_i);
  assign first_o  = at_bound;
  assign cfg_o    = cfg_q;
  assign len_m1   = (at_bound ? cfg_live_i.dss : cfg_q.dss) ? DSS_M1 : DVB_M1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else if (load_o) begin
      if (at_bound) cfg_q <= cfg_live_i;
      cnt_q <= (cnt_q == len_m1) ? '0 : cnt_q + CNT_W'(1);
    end
  end

  assert_dss_len_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0 && cfg_q.dss) |-> (cnt_q < CNT_W'(DSS_LEN)));

  assert_cfg_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> $stable(cfg_q));
endmodule

// File: rtl/ts_out_ser.sv
module ts_out_ser
  import ts_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [7:0]        data_i,
  input  logic              first_i,
  input  logic              ser_i,
  input  logic              reg_i,
  input  logic [PACE_W-1:0] pace_i,
  output logic              ready_o,
  output logic [7:0]        dout_o,
  output logic              dclk_o,
  output logic              dstb_o,
  output logic              fsync_o,
  output logic              dvalid_o
);
  logic              busy_q, phase_q, fs_q;
  logic [2:0]        idx_q;
  logic [7:0]        sh_q;
  logic [PACE_W-1:0] gap_q;
  logic [PACE_W-1:0] gap_load;
  logic              last_w, done, act;

  assign last_w   = !ser_i || (idx_q == 3'd7);
  assign gap_load = reg_i ? pace_i : '0;
  assign act      = busy_q && (gap_q == '0);
  assign done     = act && phase_q;
  // accept on the edge the gap expires so byte spacing equals bit spacing
  assign ready_o  = busy_q ? (done && last_w && gap_load == '0)
                           : (gap_q <= PACE_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      phase_q <= 1'b0;
      fs_q    <= 1'b0;
      idx_q   <= '0;
      sh_q    <= '0;
      gap_q   <= '0;
    end else begin
      if (gap_q != '0) gap_q <= gap_q - PACE_W'(1);
      if (act) begin
        if (!phase_q) begin
          phase_q <= 1'b1;
        end else begin
          phase_q <= 1'b0;
          gap_q   <= gap_load;
          if (last_w) begin
            busy_q <= 1'b0;
          end else begin
            idx_q <= idx_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end
      if (load_i) begin
        busy_q  <= 1'b1;
        phase_q <= 1'b0;
        idx_q   <= '0;
        sh_q    <= data_i;
        fs_q    <= first_i;
      end
    end
  end

  assign dvalid_o = act;
  assign dclk_o   = act && phase_q;
  assign dout_o   = !act ? 8'h00 : (ser_i ? {7'b0, sh_q[7]} : sh_q);
  assign fsync_o  = act && fs_q && (idx_q == 3'd0);
  assign dstb_o   = dclk_o && (idx_q == 3'd0);

  assert_fsync_valid_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsync_o |-> (dvalid_o && dstb_o == dclk_o));

  assert_data_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && !dclk_o) |=> (dvalid_o && dclk_o && $stable(dout_o)));

  assert_ready_blocked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && !dclk_o) |-> !ready_o);
endmodule

// File: rtl/ts_out_fmt.sv
module ts_out_fmt
  import ts_out_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        in_data_i,
  input  logic              in_sop_i,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic              fmt_dss_i,
  input  logic              serial_i,
  input  logic              regulated_i,
  input  logic [PACE_W-1:0] pace_i,
  output logic [7:0]        dout_o,
  output logic              dclk_o,
  output logic              dstb_o,
  output logic              fsync_o,
  output logic              dvalid_o
);
  cfg_t cfg_live, cfg_cur;
  logic take, load, first;

  assign cfg_live = '{dss: fmt_dss_i, ser: serial_i, reg_mode: regulated_i, pace: pace_i};
  assign take     = in_valid_i && in_ready_o;

  ts_out_pkt_ctl u_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_live_i (cfg_live),
    .take_i     (take),
    .sop_i      (in_sop_i),
    .load_o     (load),
    .first_o    (first),
    .cfg_o      (cfg_cur)
  );

  ts_out_ser u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .data_i   (in_data_i),
    .first_i  (first),
    .ser_i    (cfg_cur.ser),
    .reg_i    (cfg_cur.reg_mode),
    .pace_i   (cfg_cur.pace),
    .ready_o  (in_ready_o),
    .dout_o   (dout_o),
    .dclk_o   (dclk_o),
    .dstb_o   (dstb_o),
    .fsync_o  (fsync_o),
    .dvalid_o (dvalid_o)
  );
endmodule

// File: tb/tb_ts_out_fmt.sv
`timescale 1ns/1ps
module tb_ts_out_fmt;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_sop = 1'b0, in_valid = 1'b0, in_ready;
  logic       fmt_dss = 1'b0, serial = 1'b0, regulated = 1'b0;
  logic [7:0] pace = '0;
  logic [7:0] dout;
  logic       dclk, dstb, fsync, dvalid;

  always #2.5 clk = ~clk;

  ts_out_fmt dut (
    .clk_i(clk), .rst_ni(rst_n), .in_data_i(in_data), .in_sop_i(in_sop),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .fmt_dss_i(fmt_dss),
    .serial_i(serial), .regulated_i(regulated), .pace_i(pace),
    .dout_o(dout), .dclk_o(dclk), .dstb_o(dstb), .fsync_o(fsync), .dvalid_o(dvalid)
  );

  int checks = 0, failures = 0, cyc = 0;
  bit finished = 0;
  always @(posedge clk) cyc++;

  // word capture: one entry per high cycle
  logic [7:0] cap_d [4096];
  logic       cap_fs[4096];
  logic       cap_st[4096];
  int         cap_t [4096];
  int         ncap = 0, stab_err = 0;
  logic [7:0] p0_d = '0;
  logic       p0_seen = 1'b0;

  always @(negedge clk) begin
    if (dvalid && !dclk) begin
      p0_d = dout; p0_seen = 1'b1;
    end else if (dvalid && dclk) begin
      if (!p0_seen || dout != p0_d) stab_err++;
      p0_seen = 1'b0;
      if (ncap < 4096) begin
        cap_d[ncap] = dout; cap_fs[ncap] = fsync; cap_st[ncap] = dstb; cap_t[ncap] = cyc;
      end
      ncap++;
    end else if (dstb) stab_err++;
  end

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(int v, int p, int i);
    return 8'(v * 53 + p * 29 + i * 11 + 1);
  endfunction

  task automatic send_byte(logic [7:0] d, logic s);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_sop = s;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic go_idle(int n);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_reset_state(string tag);
    chk(!dvalid && !dclk && !dstb && !fsync && dout == 8'h00, {tag, " R10 outputs"},
        {dvalid, dclk, dstb, fsync}, 0);
    chk(in_ready == 1'b1, {tag, " R10 ready"}, in_ready, 1);
  endtask

  // dss, ser, reg, pace, input gap, packets
  localparam int NV = 6;
  localparam int VEC [NV][6] = '{
    '{0, 0, 0, 0, 0, 2},
    '{1, 0, 0, 0, 2, 2},
    '{0, 1, 0, 0, 0, 1},
    '{1, 1, 1, 3, 0, 1},
    '{0, 0, 1, 5, 0, 2},
    '{1, 1, 0, 0, 1, 1}
  };

  initial begin
    repeat (3) @(negedge clk);
    chk_reset_state("in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk_reset_state("after reset");

    for (int v = 0; v < NV; v++) begin
      automatic int len, wpb, ed = 0, ef = 0, es = 0, sp = 0, gapw;
      @(negedge clk);
      fmt_dss = VEC[v][0][0]; serial = VEC[v][1][0]; regulated = VEC[v][2][0];
      pace = 8'(VEC[v][3]);
      ncap = 0; stab_err = 0;
      len = VEC[v][0] != 0 ? 144 : 188;
      wpb = VEC[v][1] != 0 ? 8 : 1;
      for (int p = 0; p < VEC[v][5]; p++)
        for (int i = 0; i < len; i++) begin
          send_byte(pat(v, p, i), i == 0);
          if (VEC[v][4] != 0) go_idle(VEC[v][4]);
        end
      go_idle(120);
      chk(ncap == VEC[v][5] * len * wpb, $sformatf("R1 word count vec%0d", v),
          ncap, VEC[v][5] * len * wpb);
      gapw = 2 + (VEC[v][2] != 0 ? VEC[v][3] : 0);
      for (int w = 0; w < ncap && w < 4096; w++) begin
        automatic int b = w / wpb, k = w % wpb;
        automatic logic [7:0] byt = pat(v, b / len, b % len);
        automatic logic [7:0] exp = (wpb == 8) ? {7'b0, byt[7 - k]} : byt;
        if (cap_d[w] != exp) ed++;
        if (cap_fs[w] != (b % len == 0 && k == 0)) ef++;
        if (cap_st[w] != (k == 0)) es++;
        if (w > 0 && cap_t[w] - cap_t[w-1] != gapw) sp++;
      end
      chk(ed == 0, $sformatf("%s data vec%0d", wpb == 8 ? "R3" : "R2", v), ed, 0);
      chk(ef == 0, $sformatf("R4 frame sync vec%0d", v), ef, 0);
      chk(es == 0, $sformatf("R4 strobe vec%0d", v), es, 0);
      chk(stab_err == 0, $sformatf("R5 word phases vec%0d", v), stab_err, 0);
      if (VEC[v][4] == 0)
        chk(sp == 0, $sformatf("R6 spacing vec%0d", v), sp, 0);
    end

    // R7: bytes before a start marker are dropped
    begin
      @(negedge clk);
      fmt_dss = 1'b1; serial = 1'b0; regulated = 1'b0; pace = '0;
      ncap = 0;
      for (int j = 0; j < 3; j++) send_byte(8'hA5, 1'b0);
      for (int i = 0; i < 144; i++) send_byte(pat(9, 0, i), i == 0);
      go_idle(60);
      chk(ncap == 144, "R7 dropped bytes word count", ncap, 144);
      chk(cap_d[0] == pat(9, 0, 0) && cap_fs[0], "R7 first word", cap_d[0], pat(9, 0, 0));
    end

    // R8: configuration change mid-packet deferred
    begin
      automatic int ed = 0, nfs = 0;
      @(negedge clk);
      fmt_dss = 1'b0; serial = 1'b0;
      ncap = 0;
      for (int i = 0; i < 188; i++) begin
        send_byte(pat(10, 0, i), i == 0);
        if (i == 10) begin fmt_dss = 1'b1; serial = 1'b1; end
      end
      for (int i = 0; i < 144; i++) send_byte(pat(10, 1, i), i == 0);
      go_idle(60);
      chk(ncap == 188 + 1152, "R8 word count", ncap, 188 + 1152);
      for (int w = 0; w < 188; w++) if (cap_d[w] != pat(10, 0, w)) ed++;
      for (int w = 0; w < ncap && w < 4096; w++) if (cap_fs[w]) nfs++;
      chk(ed == 0, "R8 first packet stays parallel", ed, 0);
      chk(nfs == 2 && cap_fs[188], "R8 frame sync positions", nfs, 2);
      chk(cap_d[188] == {7'b0, pat(10, 1, 0)[7]}, "R8 second packet serial", cap_d[188],
          {7'b0, pat(10, 1, 0)[7]});
    end

    // R9: stall length in serial gapped mode, after a fresh reset
    begin
      automatic int n = 0;
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk_reset_state("mid-run reset");
      rst_n = 1'b1;
      fmt_dss = 1'b1; serial = 1'b1; regulated = 1'b0;
      send_byte(8'h3C, 1'b1);
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0;
      while (!in_ready && n < 100) begin n++; @(negedge clk); end
      chk(n == 15, "R9 ready low cycles", n, 15);
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule